// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the program counter value that follows a control-transfer instruction in a processor with a 16-bit program space. The decoder hands it the address of the next sequential instruction (the current address already advanced by the instruction length: two bytes for relative and in-page branches, three for long branches). It also supplies a branch kind code, the operands every branch form might use, and a taken flag that the flag and bit logic has already computed. The block does not look at flags, fetch code or touch the stack.

Four target forms are supported. A relative branch adds a sign-extended byte to the sequential address, reaching from 128 bytes back to 127 bytes ahead. An in-page branch keeps the 5-bit page number of the sequential address and puts an 11-bit operand below it, which selects one of 32 pages of 2 KB. A long branch loads a full 16-bit operand. An indirect jump goes to the data pointer plus the unsigned accumulator. Every conditional branch is relative, so the taken flag only matters for that kind. All sums wrap modulo 65536. When the REG_OUT parameter is set (the default), the result is registered.

Top module: `branch_target_gen`

## Requirements
- R1: With REG_OUT=1, while `rst` is high at a rising clock edge, `next_pc_o` becomes 0000h whatever the other inputs are.
- R2: With REG_OUT=1, `next_pc_o` shows the result for the inputs sampled at the previous rising edge.
- R3: Kind code 1 (relative) with `cond_taken_i`=1 gives `seq_pc_i` plus `rel_off_i` read as a two's-complement byte (-128..+127), modulo 65536, including across page boundaries.
- R4: Kind code 1 with `cond_taken_i`=0 gives `seq_pc_i`.
- R5: Kind code 2 (in-page) gives `{seq_pc_i[15:11], page_addr_i[10:0]}`. The page therefore comes from the sequential address, even when that address has already moved into the next page.
- R6: Kind code 3 (long) gives `long_addr_i` unchanged, over the whole range 0000h..FFFFh.
- R7: Kind code 4 (indirect) gives `dptr_i` plus `acc_i` zero-extended to 16 bits, modulo 65536.
- R8: Kind code 0 (no branch) and the unused codes 5, 6 and 7 give `seq_pc_i`.
- R9: `cond_taken_i` has no effect on kind codes 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| br_kind_i | input | 3 | Branch kind: 0 none, 1 relative, 2 in-page, 3 long, 4 indirect |
| cond_taken_i | input | 1 | Condition result for relative branches |
| seq_pc_i | input | 16 | Address of the next sequential instruction |
| rel_off_i | input | 8 | Signed relative displacement |
| page_addr_i | input | 11 | In-page target operand |
| long_addr_i | input | 16 | Full target operand |
| acc_i | input | 8 | Accumulator value for indirect jumps |
| dptr_i | input | 16 | Data pointer value for indirect jumps |
| next_pc_o | output | 16 | Next program counter |

## Verification
The bench sweeps all 256 displacements from sequential addresses next to page edges and at both ends of the address space. A design that zero-extends the byte would jump forward instead of back, and one that takes the page from the unwrapped sum would be off by one page. In-page jumps are tried from a sequential address that has just crossed into a new page, where a design that took the page bits of the branch's own address would land one page too low. Indirect jumps use every accumulator value against data pointers near FFFFh, which exposes a sign-extended accumulator and a missing wrap. The bench also flips the taken flag on non-relative kinds to catch a design that gates every branch with the taken flag.

// File: rtl/btg_pkg.sv
package btg_pkg;
  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_REL  = 3'd1,
    BR_PAGE = 3'd2,
    BR_LONG = 3'd3,
    BR_IND  = 3'd4
  } br_kind_e;
endpackage

// File: rtl/btg_rel_adder.sv
module btg_rel_adder #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  base_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  sum_o
);
  localparam int EXT_W = PC_W - OFF_W;
  logic [PC_W-1:0] off_ext;
  // two's-complement displacement widened to the address width
  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign sum_o   = base_i + off_ext;
endmodule

// File: rtl/btg_page_join.sv
module btg_page_join #(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11
) (
  input  logic [PC_W-1:0]   base_i,
  input  logic [PAGE_W-1:0] low_i,
  output logic [PC_W-1:0]   addr_o
);
  localparam int HI_W = PC_W - PAGE_W;
  logic [HI_W-1:0] page_num;
  assign page_num = base_i[PC_W-1:PAGE_W];
  assign addr_o   = {page_num, low_i};
endmodule

// File: rtl/btg_ind_adder.sv
module btg_ind_adder #(
  parameter int PC_W  = 16,
  parameter int ACC_W = 8
) (
  input  logic [PC_W-1:0]  ptr_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [PC_W-1:0]  sum_o
);
  localparam int PAD_W = PC_W - ACC_W;
  logic [PC_W-1:0] acc_ext;
  // accumulator is an unsigned index
  assign acc_ext = {{PAD_W{1'b0}}, acc_i};
  assign sum_o   = ptr_i + acc_ext;
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
  parameter int PC_W    = 16,
  parameter int OFF_W   = 8,
  parameter int PAGE_W  = 11,
  parameter int ACC_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        br_kind_i,
  input  logic              cond_taken_i,
  input  logic [PC_W-1:0]   seq_pc_i,
  input  logic [OFF_W-1:0]  rel_off_i,
  input  logic [PAGE_W-1:0] page_addr_i,
  input  logic [PC_W-1:0]   long_addr_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [PC_W-1:0]   dptr_i,
  output logic [PC_W-1:0]   next_pc_o
);
  import btg_pkg::*;

  localparam int HI_W  = PC_W - PAGE_W;
  localparam int EXT_W = PC_W - OFF_W;
  localparam int PAD_W = PC_W - ACC_W;

  br_kind_e        kind;
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] page_tgt;
  logic [PC_W-1:0] ind_tgt;
  logic [PC_W-1:0] pc_nxt;

  assign kind = br_kind_e'(br_kind_i);

  btg_rel_adder #(.PC_W(PC_W), .OFF_W(OFF_W)) u_rel (
    .base_i (seq_pc_i),
    .off_i  (rel_off_i),
    .sum_o  (rel_tgt)
  );

  btg_page_join #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_page (
    .base_i (seq_pc_i),
    .low_i  (page_addr_i),
    .addr_o (page_tgt)
  );

  btg_ind_adder #(.PC_W(PC_W), .ACC_W(ACC_W)) u_ind (
    .ptr_i  (dptr_i),
    .acc_i  (acc_i),
    .sum_o  (ind_tgt)
  );

  // only relative branches are conditional
  always_comb begin
    unique case (kind)
      BR_REL:  pc_nxt = cond_taken_i ? rel_tgt : seq_pc_i;
      BR_PAGE: pc_nxt = page_tgt;
      BR_LONG: pc_nxt = long_addr_i;
      BR_IND:  pc_nxt = ind_tgt;
      default: pc_nxt = seq_pc_i;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [PC_W-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
      end
      assign next_pc_o = pc_q;

      assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> next_pc_o == '0);

      assert_rel_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (br_kind_i == 3'd1 && cond_taken_i) |=>
          (PC_W'(next_pc_o - $past(seq_pc_i)) ==
           {{EXT_W{$past(rel_off_i[OFF_W-1])}}, $past(rel_off_i)}));

      assert_rel_fallthru_R4: assert property (@(posedge clk) disable iff (rst)
        (br_kind_i == 3'd1 && !cond_taken_i) |=> next_pc_o == $past(seq_pc_i));

      assert_page_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (br_kind_i == 3'd2) |=>
          (next_pc_o[PC_W-1:PAGE_W] == $past(seq_pc_i[PC_W-1:PAGE_W]) &&
           next_pc_o[PAGE_W-1:0] == $past(page_addr_i)));

      assert_long_load_R6: assert property (@(posedge clk) disable iff (rst)
        (br_kind_i == 3'd3) |=> next_pc_o == $past(long_addr_i));

      assert_ind_sum_R7: assert property (@(posedge clk) disable iff (rst)
        (br_kind_i == 3'd4) |=>
          (PC_W'(next_pc_o - $past(dptr_i)) == {{PAD_W{1'b0}}, $past(acc_i)}));

      assert_no_branch_R8: assert property (@(posedge clk) disable iff (rst)
        (br_kind_i == 3'd0 || br_kind_i > 3'd4) |=> next_pc_o == $past(seq_pc_i));
    end else begin : g_comb
      assign next_pc_o = pc_nxt;
    end
  endgenerate

  initial begin
    assert_widths_R5: assert (PAGE_W < PC_W && OFF_W < PC_W && ACC_W < PC_W && HI_W > 0)
      else $error("address widths inconsistent");
  end
endmodule

// File: tb/branch_target_gen_tb.sv
module branch_target_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  kind = '0;
  logic        cond = 1'b0;
  logic [15:0] seq_pc = '0;
  logic [7:0]  off = '0;
  logic [10:0] pg = '0;
  logic [15:0] lng = '0;
  logic [7:0]  acc = '0;
  logic [15:0] dptr = '0;
  logic [15:0] next_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  branch_target_gen u_dut (
    .clk(clk), .rst(rst), .br_kind_i(kind), .cond_taken_i(cond),
    .seq_pc_i(seq_pc), .rel_off_i(off), .page_addr_i(pg),
    .long_addr_i(lng), .acc_i(acc), .dptr_i(dptr), .next_pc_o(next_pc)
  );

  function automatic logic [15:0] wrap16(int v);
    return 16'(((v % 65536) + 65536) % 65536);
  endfunction

  function automatic logic [15:0] exp_rel(logic [15:0] s, logic [7:0] o);
    int d = int'(o);
    if (d > 127) d = d - 256;
    return wrap16(int'(s) + d);
  endfunction

  task automatic check(string req, logic [15:0] exp);
    n_chk++;
    if (next_pc !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, next_pc, exp);
    end
  endtask

  // drive at a falling edge, result appears after the next rising edge
  task automatic step(logic [2:0] k, logic c, logic [15:0] s, logic [7:0] o,
                      logic [10:0] p, logic [15:0] l, logic [7:0] a,
                      logic [15:0] d, logic [15:0] exp, string req);
    @(negedge clk);
    kind = k; cond = c; seq_pc = s; off = o; pg = p; lng = l; acc = a; dptr = d;
    @(negedge clk);
    check(req, exp);
  endtask

  initial begin
    logic [15:0] bases [7];
    bases = '{16'h0000, 16'h0005, 16'h07F0, 16'h0800, 16'h7FFF, 16'hFFF0, 16'hFFFF};

    // R1: reset clears the output despite busy inputs
    kind = 3'd3; lng = 16'hBEEF; seq_pc = 16'h1234;
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);
    rst = 1'b0;
    // R2: one-cycle latency, first value after reset
    @(negedge clk);
    check("R2", 16'hBEEF);

    // R3 / R4: every displacement, taken and not taken
    foreach (bases[b]) begin
      for (int o = 0; o < 256; o++) begin
        step(3'd1, 1'b1, bases[b], 8'(o), 11'h155, 16'h4444, 8'h11, 16'h2222,
             exp_rel(bases[b], 8'(o)), "R3");
        step(3'd1, 1'b0, bases[b], 8'(o), 11'h155, 16'h4444, 8'h11, 16'h2222,
             bases[b], "R4");
      end
    end
    // R3: backward branch crossing a page edge
    step(3'd1, 1'b1, 16'h0802, 8'hF0, '0, '0, '0, '0, 16'h07F2, "R3");

    // R5: every in-page operand; 0800h is the sequential address after a
    // branch in the last two bytes of page 0, so the target lies in page 1
    for (int p = 0; p < 2048; p++) begin
      step(3'd2, 1'b1, 16'h0800, 8'h80, 11'(p), 16'h0, 8'h0, 16'h0,
           16'h0800 | 16'(p), "R5");
      step(3'd2, 1'b1, 16'hF801, 8'h7F, 11'(p), 16'h0, 8'h0, 16'h0,
           16'hF800 | 16'(p), "R5");
    end

    // R6: long loads across the range, including both ends
    for (int l = 0; l < 65536; l += 97)
      step(3'd3, 1'b1, 16'h0103, 8'h80, 11'h7FF, 16'(l), 8'hFF, 16'hFFFF, 16'(l), "R6");
    step(3'd3, 1'b1, 16'h0103, '0, '0, 16'h0000, '0, '0, 16'h0000, "R6");
    step(3'd3, 1'b1, 16'h0103, '0, '0, 16'hFFFF, '0, '0, 16'hFFFF, "R6");

    // R7: every accumulator value, data pointers near the top
    for (int a = 0; a < 256; a++) begin
      step(3'd4, 1'b1, 16'h0, 8'h0, 11'h0, 16'h0, 8'(a), 16'h0000, 16'(a), "R7");
      step(3'd4, 1'b1, 16'h0, 8'h0, 11'h0, 16'h0, 8'(a), 16'h1234,
           wrap16(32'h1234 + a), "R7");
      step(3'd4, 1'b1, 16'h0, 8'h0, 11'h0, 16'h0, 8'(a), 16'hFF80,
           wrap16(32'hFF80 + a), "R7");
      step(3'd4, 1'b1, 16'h0, 8'h0, 11'h0, 16'h0, 8'(a), 16'hFFFF,
           wrap16(32'hFFFF + a), "R7");
    end

    // R8: no-branch and unused codes
    for (int k = 0; k < 8; k++) begin
      if (k >= 1 && k <= 4) continue;
      step(3'(k), 1'b1, 16'hA5C3, 8'h80, 11'h7FF, 16'h1111, 8'hFF, 16'hFFFF, 16'hA5C3, "R8");
      step(3'(k), 1'b0, 16'h0FFF, 8'h7F, 11'h001, 16'h2222, 8'h01, 16'h0001, 16'h0FFF, "R8");
    end

    // R9: taken flag low leaves non-relative kinds unaffected
    for (int i = 0; i < 64; i++) begin
      logic [15:0] s = 16'(i * 1031 + 7);
      step(3'd2, 1'b0, s, 8'h80, 11'(i * 29), 16'h0, 8'h0, 16'h0,
           {s[15:11], 11'(i * 29)}, "R9");
      step(3'd3, 1'b0, s, 8'h80, 11'h0, 16'(i * 977), 8'h0, 16'h0, 16'(i * 977), "R9");
      step(3'd4, 1'b0, s, 8'h80, 11'h0, 16'h0, 8'(i * 5), 16'(i * 1013),
           wrap16(i * 1013 + ((i * 5) % 256)), "R9");
    end

    // R1 again: reset asserted mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);
    rst = 1'b0;

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule